// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block is the arithmetic and logic slice of a 16-bit load/store processor. It holds the eight general-purpose registers and the three-state sign flag register (negative, zero, positive). When it is handed a valid 16-bit instruction word, it decodes the operate fields. It reads one or two source registers, or one register and a sign-extended immediate, and computes an add, a bitwise AND or a bitwise complement. It writes the result back to the destination register and records the sign of the result in the flags.

The load path of the processor lives outside this block. When a load completes, its value is presented on a separate writeback input. The block writes that value to the named register and updates the flags from it, exactly as for an operate result. Every register write, from either source, is also reported on a registered writeback port one cycle after it is requested, together with the flags it produced.

Top module: `alu_ccr_core`

## Requirements
- R1: While reset is high and in the first cycle after it, flags read N=0 Z=1 P=0 (`cc_flags` = 3'b010, bit 2 N, bit 1 Z, bit 0 P) and `wb_valid` is 0. Every register reads as zero until it is first written.
- R2: Opcode instr[15:12]=4'b0001 with instr[5]=0 writes reg[instr[8:6]] + reg[instr[2:0]] into reg[instr[11:9]], wrapping modulo 2^16 with no carry or overflow output.
- R3: With instr[5]=1, the second operand of add and AND is instr[4:0] sign-extended to 16 bits (range -16 to +15).
- R4: Opcode 4'b0101 writes the bitwise AND of the first source and the second operand, in register or immediate form.
- R5: Opcode 4'b1001 writes the bitwise complement of reg[instr[8:6]] into reg[instr[11:9]]; instr[5:0] has no effect on the result.
- R6: After every register write exactly one flag is set: N when bit 15 of the written value is 1, Z when the value is zero, P otherwise.
- R7: A load writeback (`ld_wr_en`=1) writes `ld_wr_data` into reg[`ld_wr_dst`] and updates the flags by the rule of R6.
- R8: Each write appears on `wb_valid`/`wb_dst`/`wb_data` in the following cycle. An instruction issued in the cycle right after a write reads the new value. A read in the same cycle as a write to that register returns the old value.
- R9: A valid instruction with any other opcode writes no register, leaves the flags unchanged and raises no `wb_valid`.
- R10: In any cycle without a register write, the flags keep their value and `wb_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| ld_wr_en | input | 1 | Load writeback request |
| ld_wr_dst | input | 3 | Load destination register |
| ld_wr_data | input | 16 | Load value |
| wb_valid | output | 1 | A register was written in the previous cycle |
| wb_dst | output | 3 | Register that was written |
| wb_data | output | 16 | Value that was written |
| cc_flags | output | 3 | Flags {N, Z, P} |

## Verification
The assertions assume that the core never asks for an operate write and a load write in the same cycle, since the single write port can serve only one. An assertion on the inputs states this. The directed stimulus drives the instruction and load inputs only from separate tasks, so the two writers never overlap. The flag checks also assume that reset is applied before the first instruction. The bench does this before any other activity.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned FLD_W   = 3;

  typedef enum logic [3:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opc_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_INV = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;
endpackage

// File: rtl/opu_regfile.sv
module opu_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  // storage has no reset so it can map to distributed RAM; a per-entry
  // written bit makes never-written entries read as zero
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[waddr] <= 1'b1;
  end

  assign ra_data = written[ra_addr] ? mem[ra_addr] : '0;
  assign rb_data = written[rb_addr] ? mem[rb_addr] : '0;

  // R8: a write is visible on a read port in the very next cycle
  p_rd_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> (ra_addr != $past(waddr)) || (ra_data == $past(wdata)));

  // R1: nothing written since reset reads as zero
  p_clear_after_rst_r1: assert property (@(posedge clk)
    rst |=> (ra_data == '0) && (rb_data == '0));
endmodule

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               legal,
  output alu_fn_e            fn,
  output logic [FLD_W-1:0]   dst,
  output logic [FLD_W-1:0]   src1,
  output logic [FLD_W-1:0]   src2,
  output logic               use_imm,
  output logic [DATA_W-1:0]  imm
);
  localparam int unsigned IMM_W = 5;

  assign dst     = instr[11:9];
  assign src1    = instr[8:6];
  assign src2    = instr[2:0];
  assign use_imm = instr[5];
  assign imm     = {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  always_comb begin
    legal = 1'b1;
    fn    = FN_ADD;
    unique case (instr[15:12])
      OPC_ADD: fn = FN_ADD;
      OPC_AND: fn = FN_AND;
      OPC_NOT: fn = FN_INV;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [DATA_W-1:0] b_imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] b;
  assign b = use_imm ? b_imm : b_reg;

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_AND:  y = a & b;
      FN_INV:  y = ~a;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/opu_ccr.sv
module opu_ccr
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] value,
  output cc_t               cc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    end else if (upd) begin
      cc.n <= value[DATA_W-1];
      cc.z <= (value == '0);
      cc.p <= !value[DATA_W-1] && (value != '0);
    end
  end

  // R6: exactly one flag set at all times after reset
  p_cc_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(cc) == 1);

  // R6: a negative write leaves N, a zero write leaves Z
  p_cc_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && value[DATA_W-1]) |=> cc.n);
  p_cc_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && value == '0) |=> cc.z);

  // R10: no write, no flag change
  p_cc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(cc));

  // R1: reset value of the flags
  p_cc_reset_r1: assert property (@(posedge clk)
    rst |=> (cc == 3'b010));
endmodule

// File: rtl/alu_ccr_core.sv
module alu_ccr_core
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic              ld_wr_en,
  input  logic [AW-1:0]     ld_wr_dst,
  input  logic [DATA_W-1:0] ld_wr_data,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output logic [2:0]        cc_flags
);
  logic              legal, use_imm;
  alu_fn_e           fn;
  logic [FLD_W-1:0]  dst, src1, src2;
  logic [DATA_W-1:0] imm, ra, rb, alu_y;
  logic              op_we, we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;
  cc_t               cc;

  opu_decode #(.DATA_W(DATA_W)) u_dec (
    .instr(instr), .legal(legal), .fn(fn), .dst(dst), .src1(src1),
    .src2(src2), .use_imm(use_imm), .imm(imm)
  );

  opu_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS)) u_rf (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .ra_addr(AW'(src1)), .ra_data(ra), .rb_addr(AW'(src2)), .rb_data(rb)
  );

  opu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn(fn), .a(ra), .b_reg(rb), .b_imm(imm), .use_imm(use_imm), .y(alu_y)
  );

  assign op_we = instr_valid && legal;
  assign we    = op_we || ld_wr_en;
  assign waddr = op_we ? AW'(dst) : ld_wr_dst;
  assign wdata = op_we ? alu_y : ld_wr_data;

  opu_ccr #(.DATA_W(DATA_W)) u_ccr (
    .clk(clk), .rst(rst), .upd(we), .value(wdata), .cc(cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= we;
      wb_dst   <= waddr;
      wb_data  <= wdata;
    end
  end

  assign cc_flags = cc;

  // R7: input assumption, one writer per cycle
  p_one_writer_r7: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && legal && ld_wr_en));

  // R9: an unrecognized opcode produces no writeback
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !legal && !ld_wr_en) |=> !wb_valid);

  // R8: a legal operate is reported next cycle on its destination
  p_op_reported_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && legal) |=> wb_valid && (wb_dst == $past(instr[11:9])));

  // R7: a load is reported next cycle with its data
  p_ld_reported_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_wr_en && !instr_valid) |=> wb_valid && (wb_data == $past(ld_wr_data)));

  // R10: idle cycle gives no writeback
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid && !ld_wr_en) |=> !wb_valid);
endmodule

// File: tb/sim_alu_ccr_core.sv
`timescale 1ns/1ps
module sim_alu_ccr_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        ld_wr_en = 1'b0;
  logic [2:0]  ld_wr_dst = '0;
  logic [15:0] ld_wr_data = '0;
  logic        wb_valid;
  logic [2:0]  wb_dst;
  logic [15:0] wb_data;
  logic [2:0]  cc_flags;

  int checks = 0;
  int failures = 0;

  logic [15:0] mreg [8];
  logic [2:0]  mcc;

  always #2.5 clk = ~clk;

  alu_ccr_core u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .ld_wr_en(ld_wr_en), .ld_wr_dst(ld_wr_dst), .ld_wr_data(ld_wr_data),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data), .cc_flags(cc_flags)
  );

  function automatic logic [15:0] add_r(input int d, input int s1, input int s2);
    return {4'b0001, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] add_i(input int d, input int s1, input int im);
    return {4'b0001, 3'(d), 3'(s1), 1'b1, 5'(im)};
  endfunction
  function automatic logic [15:0] and_r(input int d, input int s1, input int s2);
    return {4'b0101, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] and_i(input int d, input int s1, input int im);
    return {4'b0101, 3'(d), 3'(s1), 1'b1, 5'(im)};
  endfunction
  function automatic logic [15:0] not_r(input int d, input int s, input logic [5:0] low);
    return {4'b1001, 3'(d), 3'(s), low};
  endfunction

  function automatic logic [2:0] cc_of(input logic [15:0] v);
    if (v[15])        return 3'b100;
    else if (v == 0)  return 3'b010;
    else              return 3'b001;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one instruction from a falling edge, check one cycle later
  task automatic op(input logic [15:0] ins, input string req);
    logic        ok;
    logic [15:0] a, b, res;
    a  = mreg[ins[8:6]];
    b  = ins[5] ? {{11{ins[4]}}, ins[4:0]} : mreg[ins[2:0]];
    ok = 1'b1;
    case (ins[15:12])
      4'b0001: res = a + b;
      4'b0101: res = a & b;
      4'b1001: res = ~a;
      default: begin ok = 1'b0; res = '0; end
    endcase
    instr = ins; instr_valid = 1'b1; ld_wr_en = 1'b0;
    @(negedge clk);
    if (ok) begin
      chk(req, "wb_valid", 32'(wb_valid), 32'd1);
      chk(req, "wb_dst",   32'(wb_dst),   32'(ins[11:9]));
      chk(req, "wb_data",  32'(wb_data),  32'(res));
      chk("R6", "cc_flags", 32'(cc_flags), 32'(cc_of(res)));
      mreg[ins[11:9]] = res;
      mcc = cc_of(res);
    end else begin
      chk(req, "wb_valid", 32'(wb_valid), 32'd0);
      chk(req, "cc_flags", 32'(cc_flags), 32'(mcc));
    end
  endtask

  task automatic ld(input int d, input logic [15:0] v, input string req);
    instr_valid = 1'b0; ld_wr_en = 1'b1; ld_wr_dst = 3'(d); ld_wr_data = v;
    @(negedge clk);
    chk(req, "wb_valid", 32'(wb_valid), 32'd1);
    chk(req, "wb_dst",   32'(wb_dst),   32'(d));
    chk(req, "wb_data",  32'(wb_data),  32'(v));
    chk(req, "cc_flags", 32'(cc_flags), 32'(cc_of(v)));
    mreg[d] = v;
    mcc = cc_of(v);
  endtask

  task automatic idle(input int n, input string req);
    instr_valid = 1'b0; ld_wr_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle wb_valid", 32'(wb_valid), 32'd0);
      chk(req, "idle cc_flags", 32'(cc_flags), 32'(mcc));
    end
  endtask

  task automatic peek(input int r, input string req);
    op(add_i(r, r, 0), req);
  endtask

  task automatic t_reset_r1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "cc in reset", 32'(cc_flags), 32'b010);
    chk("R1", "wb_valid in reset", 32'(wb_valid), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mcc = 3'b010;
    idle(1, "R1");
    for (int r = 0; r < 8; r++) peek(r, "R1");
  endtask

  task automatic t_add_reg_r2;
    ld(1, 16'h1234, "R7");
    ld(2, 16'h0101, "R7");
    op(add_r(3, 1, 2), "R2");
    ld(4, 16'h7FFF, "R7");
    ld(5, 16'h0001, "R7");
    op(add_r(6, 4, 5), "R2");
    ld(4, 16'hFFFF, "R7");
    op(add_r(7, 4, 5), "R2");
    op(add_r(0, 3, 3), "R2");
    idle(1, "R10");
  endtask

  task automatic t_add_imm_r3;
    ld(2, 16'h0010, "R7");
    op(add_i(1, 2, -16), "R3");
    op(add_i(1, 2, 15), "R3");
    op(add_i(1, 2, -1), "R3");
    ld(3, 16'h0000, "R7");
    op(add_i(4, 3, -5), "R3");
    idle(1, "R10");
  endtask

  task automatic t_and_r4;
    ld(1, 16'hF0F0, "R7");
    ld(2, 16'h3C3C, "R7");
    op(and_r(3, 1, 2), "R4");
    op(and_i(4, 1, 0), "R4");
    op(and_i(5, 1, -1), "R4");
    op(and_i(6, 2, 12), "R4");
    idle(1, "R10");
  endtask

  task automatic t_not_r5;
    ld(1, 16'h00FF, "R7");
    op(not_r(2, 1, 6'b111111), "R5");
    op(not_r(3, 1, 6'b000000), "R5");
    op(not_r(4, 1, 6'b101010), "R5");
    ld(5, 16'hFFFF, "R7");
    op(not_r(6, 5, 6'b111111), "R5");
    idle(1, "R10");
  endtask

  task automatic t_load_r7;
    ld(0, 16'h8000, "R7");
    ld(1, 16'h0000, "R7");
    ld(2, 16'h0042, "R7");
    op(add_r(3, 0, 2), "R7");
    idle(1, "R10");
  endtask

  task automatic t_b2b_r8;
    ld(1, 16'h0005, "R8");
    op(add_i(1, 1, 1), "R8");
    op(add_i(1, 1, 1), "R8");
    op(add_i(2, 1, -7), "R8");
    op(and_r(3, 2, 1), "R8");
    ld(4, 16'hABCD, "R8");
    op(add_i(5, 4, 0), "R8");
    idle(1, "R10");
  endtask

  task automatic t_illegal_r9;
    ld(6, 16'h1357, "R9");
    op({4'b0010, 3'd6, 9'h000}, "R9");
    op({4'b1111, 3'd6, 9'h1FF}, "R9");
    op({4'b1101, 3'd6, 3'd6, 6'h3F}, "R9");
    idle(1, "R9");
    peek(6, "R9");
  endtask

  task automatic t_hold_r10;
    ld(2, 16'hC000, "R10");
    idle(4, "R10");
    ld(2, 16'h0003, "R10");
    idle(3, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_add_reg_r2();
    t_add_imm_r3();
    t_and_r4();
    t_not_r5();
    t_load_r7();
    t_b2b_r8();
    t_illegal_r9();
    t_hold_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule